// File: doc/BRIEF.md
# Parallel Byte-Lane Table Lookup Unit

This unit accelerates table-driven symmetric ciphers. A word of `W_BITS` bits (32, 64 or 128) is split into byte lanes, and each lane owns a private table of 256 entries of 32 bits. A lookup command uses every byte of the source word as the index into its own lane's table. All lanes read together, and the 32-bit lane results are merged into one result word. The merge either folds all lane results together with XOR or packs one byte from each lane side by side. An optional masking step keeps one chosen byte position of every lane result and clears the rest before the merge.

The tables are filled through a separate write port that works alongside the lookup port. A strided write takes a starting lane offset from 0 to 3 and stores one 32-bit word into each table at offset, offset+4, offset+8 and so on, each table taking its own slice of the write data. A broadcast write stores one 32-bit word into every table at the same index. The result register is driven by a two-state machine. `ST_IDLE` means no result is being presented. `ST_EMIT` means the result of the previous cycle's lookup is on `res_data` with `res_valid` high. The transition into `ST_EMIT` is taken on every edge where `lk_valid` is high, and the transition into `ST_IDLE` is taken on every edge where it is low, so back-to-back lookups stay in `ST_EMIT`.

Top module: `byte_lane_lookup`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is high in exactly the cycles that follow a clock edge where `lk_valid` was high, so a lookup has a latency of one clock and back-to-back lookups give one result per cycle.
- R3: Lane i (table i) is indexed by byte i of `lk_src`, where byte 0 is bits [7:0].
- R4: With `lk_subop` = 0, bits [31:0] of `res_data` are the XOR of all lane results, and every bit above 31 is zero.
- R5: With `lk_subop` = 1, bits [8i+7:8i] of `res_data` hold bits [7:0] of lane i's result.
- R6: With `lk_masked` = 1, each lane result keeps only bits [8k+7:8k], where k = `lk_keep_byte`, and its other bits are cleared before the merge. With `lk_masked` = 0, lane results are used whole.
- R7: `wr_op` = 1 (strided) writes `wr_data[32j+31:32j]` into table `wr_lane_ofs`+4j at `wr_index`, for every j, and leaves all other tables unchanged.
- R8: `wr_op` = 2 (broadcast) writes `wr_data[31:0]` into every table at `wr_index`.
- R9: `wr_op` = 0 or `wr_op` = 3 changes no table entry.
- R10: A lookup issued in the same cycle as a write returns the table contents from before that write. The written value is seen by lookups in later cycles.
- R11: `res_data` keeps its last value on every edge where `lk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Issue a lookup this cycle |
| lk_masked | input | 1 | Apply byte masking to the lane results |
| lk_keep_byte | input | 2 | Byte position kept when masking |
| lk_subop | input | 1 | Merge mode: 0 = XOR fold, 1 = byte pack |
| lk_src | input | W_BITS | Source word; byte i indexes table i |
| wr_op | input | 2 | Write command: 0 none, 1 strided, 2 broadcast, 3 none |
| wr_lane_ofs | input | 2 | First lane of a strided write |
| wr_index | input | 8 | Table entry to write |
| wr_data | input | W_BITS | Write data; 32-bit slice j goes to the j-th selected table |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | W_BITS | Merged lookup result |

## Verification
Every cycle, the assertions check the handshake timing: the reset clear, that `res_valid` follows `lk_valid` by exactly one edge, and that the result holds between lookups. They also check two merge properties that do not depend on table contents: the zero upper bits after an XOR fold, and that a masked fold leaves nothing outside the kept byte. The bench scenarios alone can show that the right table entry reaches the right lane. This covers the byte-to-lane mapping, the values the XOR and pack merges produce, which tables a strided write touches, the broadcast fill, the write commands that do nothing, and the old-data result when a write and a lookup share a cycle. Each of these is compared against a reference copy of the tables kept in the bench.

// File: rtl/blu_pkg.sv
package blu_pkg;

    localparam int ENTRY_W = 32;
    localparam int IDX_W   = 8;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int STRIDE  = 4;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_STRIDE = 2'd1,
        WR_ALL    = 2'd2,
        WR_RSVD   = 2'd3
    } wr_op_e;

    typedef enum logic {
        SUB_XOR  = 1'b0,
        SUB_PACK = 1'b1
    } subop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } res_state_e;

endpackage

// File: rtl/blu_lane_table.sv
module blu_lane_table
    import blu_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Write lands at the edge; the read is combinational, so a lookup in
    // the same cycle sees the previous contents.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/blu_write_ctl.sv
module blu_write_ctl
    import blu_pkg::*;
#(
    parameter int W_BITS = 32,
    localparam int LANES = W_BITS / 8
) (
    input  logic [1:0]                     wr_op,
    input  logic [1:0]                     wr_lane_ofs,
    input  logic [W_BITS-1:0]              wr_data,
    output logic [LANES-1:0]               lane_we,
    output logic [LANES-1:0][ENTRY_W-1:0]  lane_wdata
);

    wr_op_e op;
    assign op = wr_op_e'(wr_op);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int PHASE = g % STRIDE;
        localparam int SLICE = g / STRIDE;

        always_comb begin
            lane_we[g]    = 1'b0;
            lane_wdata[g] = wr_data[ENTRY_W-1:0];
            unique case (op)
                WR_STRIDE: begin
                    lane_we[g]    = (wr_lane_ofs == 2'(PHASE));
                    lane_wdata[g] = wr_data[SLICE*ENTRY_W +: ENTRY_W];
                end
                WR_ALL: begin
                    lane_we[g]    = 1'b1;
                    lane_wdata[g] = wr_data[ENTRY_W-1:0];
                end
                WR_IDLE, WR_RSVD: begin
                    lane_we[g]    = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/blu_merge.sv
module blu_merge
    import blu_pkg::*;
#(
    parameter int W_BITS = 32,
    localparam int LANES = W_BITS / 8
) (
    input  logic [LANES-1:0][ENTRY_W-1:0] lane_res,
    input  logic                          masked,
    input  logic [1:0]                    keep_byte,
    input  logic                          subop,
    output logic [W_BITS-1:0]             merged
);

    logic [ENTRY_W-1:0]              keep_mask;
    logic [LANES-1:0][ENTRY_W-1:0]   lane_m;
    logic [ENTRY_W-1:0]              fold;
    logic [W_BITS-1:0]               packed_w;

    assign keep_mask = masked ? (ENTRY_W'(8'hFF) << {keep_byte, 3'b000})
                              : {ENTRY_W{1'b1}};

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign lane_m[g]            = lane_res[g] & keep_mask;
        assign packed_w[g*8 +: 8]   = lane_m[g][7:0];
    end

    always_comb begin
        fold = '0;
        for (int i = 0; i < LANES; i++) begin
            fold = fold ^ lane_m[i];
        end
    end

    always_comb begin
        merged = '0;
        unique case (subop_e'(subop))
            SUB_XOR:  merged[ENTRY_W-1:0] = fold;
            SUB_PACK: merged = packed_w;
        endcase
    end

endmodule

// File: rtl/byte_lane_lookup.sv
module byte_lane_lookup
    import blu_pkg::*;
#(
    parameter int W_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_masked,
    input  logic [1:0]        lk_keep_byte,
    input  logic              lk_subop,
    input  logic [W_BITS-1:0] lk_src,
    input  logic [1:0]        wr_op,
    input  logic [1:0]        wr_lane_ofs,
    input  logic [7:0]        wr_index,
    input  logic [W_BITS-1:0] wr_data,
    output logic              res_valid,
    output logic [W_BITS-1:0] res_data
);

    localparam int LANES = W_BITS / 8;

    if (W_BITS != 32 && W_BITS != 64 && W_BITS != 128) begin : g_bad_width
        $error("byte_lane_lookup: W_BITS must be 32, 64 or 128");
    end

    logic [LANES-1:0]              lane_we;
    logic [LANES-1:0][ENTRY_W-1:0] lane_wdata;
    logic [LANES-1:0][ENTRY_W-1:0] lane_rd;
    logic [W_BITS-1:0]             merged;

    res_state_e state, state_nx;

    blu_write_ctl #(.W_BITS(W_BITS)) i_wctl (
        .wr_op       (wr_op),
        .wr_lane_ofs (wr_lane_ofs),
        .wr_data     (wr_data),
        .lane_we     (lane_we),
        .lane_wdata  (lane_wdata)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_tab
        blu_lane_table i_tab (
            .clk   (clk),
            .we    (lane_we[g]),
            .waddr (wr_index),
            .wdata (lane_wdata[g]),
            .raddr (lk_src[g*8 +: 8]),
            .rdata (lane_rd[g])
        );
    end

    blu_merge #(.W_BITS(W_BITS)) i_merge (
        .lane_res  (lane_rd),
        .masked    (lk_masked),
        .keep_byte (lk_keep_byte),
        .subop     (lk_subop),
        .merged    (merged)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = lk_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = lk_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Output register: captures the merged word on each lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (lk_valid) begin
            res_data <= merged;
        end
    end

    assign res_valid = (state == ST_EMIT);

endmodule

// File: rtl/blu_checker.sv
module blu_checker #(
    parameter int W_BITS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_masked,
    input logic [1:0]        lk_keep_byte,
    input logic              lk_subop,
    input logic              res_valid,
    input logic [W_BITS-1:0] res_data
);

    // R1: reset clears the result
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_data == '0));

    // R2: valid follows a lookup by one edge
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R2: no valid without a lookup
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R11: result held between lookups
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> $stable(res_data));

    // R6: masked fold leaves nothing outside the kept byte
    a_r6_mask_fold: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_masked && !lk_subop) |=>
        ((res_data[31:0] & ~(32'hFF << {$past(lk_keep_byte), 3'b000})) == 32'h0));

    if (W_BITS > 32) begin : g_upper
        // R4: fold leaves upper bits zero
        a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_valid && !lk_subop) |=> (res_data[W_BITS-1:32] == '0));
    end

endmodule

bind byte_lane_lookup blu_checker #(.W_BITS(W_BITS)) i_blu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_masked    (lk_masked),
    .lk_keep_byte (lk_keep_byte),
    .lk_subop     (lk_subop),
    .res_valid    (res_valid),
    .res_data     (res_data)
);

// File: tb/test_byte_lane_lookup.sv
module test_byte_lane_lookup;

    localparam int W     = 32;
    localparam int LANES = W / 8;
    localparam int NSEL  = LANES / 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lk_valid;
    logic          lk_masked;
    logic [1:0]    lk_keep_byte;
    logic          lk_subop;
    logic [W-1:0]  lk_src;
    logic [1:0]    wr_op;
    logic [1:0]    wr_lane_ofs;
    logic [7:0]    wr_index;
    logic [W-1:0]  wr_data;
    logic          res_valid;
    logic [W-1:0]  res_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] mdl [LANES][256];

    always #10 clk = ~clk;

    byte_lane_lookup #(.W_BITS(W)) i_byte_lane_lookup (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_masked(lk_masked),
        .lk_keep_byte(lk_keep_byte), .lk_subop(lk_subop), .lk_src(lk_src),
        .wr_op(wr_op), .wr_lane_ofs(wr_lane_ofs), .wr_index(wr_index),
        .wr_data(wr_data), .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [31:0] tab_val(int lane, int idx);
        return (32'(lane) * 32'h9E3779B1) ^ (32'(idx) * 32'h01000193) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [W-1:0] mk_src(int seed);
        logic [W-1:0] s;
        for (int i = 0; i < LANES; i++) s[i*8 +: 8] = 8'((seed * 37 + i * 91 + 11));
        return s;
    endfunction

    function automatic logic [W-1:0] exp_res(logic [W-1:0] src, logic m, logic [1:0] k, logic sub);
        logic [31:0]  msk, fold, v;
        logic [W-1:0] pk, r;
        msk  = m ? (32'hFF << (8 * k)) : 32'hFFFF_FFFF;
        fold = '0;
        pk   = '0;
        for (int i = 0; i < LANES; i++) begin
            v = mdl[i][src[i*8 +: 8]] & msk;
            fold ^= v;
            pk[i*8 +: 8] = v[7:0];
        end
        r = '0;
        if (sub) r = pk;
        else     r[31:0] = fold;
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle_inputs;
        lk_valid = 0; lk_masked = 0; lk_keep_byte = 0; lk_subop = 0; lk_src = '0;
        wr_op = 0; wr_lane_ofs = 0; wr_index = 0; wr_data = '0;
    endtask

    task automatic model_write(input logic [1:0] op, input logic [1:0] ofs,
                               input logic [7:0] idx, input logic [W-1:0] d);
        if (op == 2'd1) begin
            for (int j = 0; j < NSEL; j++) mdl[ofs + 4*j][idx] = d[32*j +: 32];
        end else if (op == 2'd2) begin
            for (int i = 0; i < LANES; i++) mdl[i][idx] = d[31:0];
        end
    endtask

    task automatic do_write(input logic [1:0] op, input logic [1:0] ofs,
                            input logic [7:0] idx, input logic [W-1:0] d);
        @(negedge clk);
        wr_op = op; wr_lane_ofs = ofs; wr_index = idx; wr_data = d;
        @(negedge clk);
        wr_op = 0;
        model_write(op, ofs, idx, d);
    endtask

    task automatic do_lookup(input string req, input logic [W-1:0] src,
                             input logic m, input logic [1:0] k, input logic sub);
        logic [W-1:0] e;
        e = exp_res(src, m, k, sub);
        @(negedge clk);
        lk_valid = 1; lk_src = src; lk_masked = m; lk_keep_byte = k; lk_subop = sub;
        @(negedge clk);
        lk_valid = 0;
        chk({req, " valid"}, W'(res_valid), W'(1));
        chk(req, res_data, e);
    endtask

    // R1
    task automatic t_reset;
        chk("R1 valid", W'(res_valid), W'(0));
        chk("R1 data", res_data, '0);
    endtask

    // R7: fill every table through strided writes
    task automatic t_fill;
        logic [W-1:0] d;
        for (int ofs = 0; ofs < 4; ofs++) begin
            for (int idx = 0; idx < 256; idx++) begin
                d = '0;
                for (int j = 0; j < NSEL; j++) d[32*j +: 32] = tab_val(ofs + 4*j, idx);
                do_write(2'd1, 2'(ofs), 8'(idx), d);
            end
        end
        for (int s = 0; s < 3; s++) do_lookup("R7 fill", mk_src(s), 1'b0, 2'd0, 1'b1);
    endtask

    // R3, R4: XOR fold over distinct index patterns
    task automatic t_fold;
        logic [W-1:0] src;
        for (int s = 3; s < 9; s++) do_lookup("R4 fold", mk_src(s), 1'b0, 2'd0, 1'b0);
        src = '0;
        src[7:0] = 8'd200;
        for (int i = 1; i < LANES; i++) src[i*8 +: 8] = 8'd0;
        do_lookup("R3 byte0 lane0", src, 1'b0, 2'd0, 1'b0);
    endtask

    // R5, R3: pack
    task automatic t_pack;
        logic [W-1:0] src;
        for (int i = 0; i < LANES; i++) src[i*8 +: 8] = 8'(i * 17 + 3);
        do_lookup("R5 pack", src, 1'b0, 2'd0, 1'b1);
        do_lookup("R3 pack order", mk_src(21), 1'b0, 2'd0, 1'b1);
    endtask

    // R6: masking on both merges
    task automatic t_mask;
        for (int k = 0; k < 4; k++) begin
            do_lookup("R6 mask fold", mk_src(30 + k), 1'b1, 2'(k), 1'b0);
            do_lookup("R6 mask pack", mk_src(40 + k), 1'b1, 2'(k), 1'b1);
        end
    endtask

    // R7: strided write touches only its tables
    task automatic t_stride_iso;
        logic [W-1:0] src;
        do_write(2'd1, 2'd1, 8'd9, {NSEL{32'hC0DE_77A5}});
        src = {LANES{8'd9}};
        do_lookup("R7 stride iso pack", src, 1'b0, 2'd0, 1'b1);
        do_lookup("R7 stride iso fold", src, 1'b0, 2'd0, 1'b0);
    endtask

    // R8: broadcast fill
    task automatic t_broadcast;
        logic [W-1:0] src;
        do_write(2'd2, 2'd0, 8'd77, {NSEL{32'h1234_56E1}});
        src = {LANES{8'd77}};
        do_lookup("R8 broadcast pack", src, 1'b0, 2'd0, 1'b1);
        for (int i = 0; i < LANES; i++)
            chk("R8 lane byte", W'(res_data[i*8 +: 8]), W'(8'hE1));
    endtask

    // R9: idle and reserved write codes
    task automatic t_nowrite;
        logic [W-1:0] src;
        do_write(2'd0, 2'd0, 8'd50, {NSEL{32'hDEAD_BEEF}});
        do_write(2'd3, 2'd2, 8'd50, {NSEL{32'hFACE_0FF0}});
        src = {LANES{8'd50}};
        do_lookup("R9 no write pack", src, 1'b0, 2'd0, 1'b1);
        do_lookup("R9 no write fold", src, 1'b1, 2'd3, 1'b0);
    endtask

    // R10: write and lookup in one cycle
    task automatic t_same_cycle;
        logic [W-1:0] src, e_old;
        src = {LANES{8'd123}};
        e_old = exp_res(src, 1'b0, 2'd0, 1'b1);
        @(negedge clk);
        lk_valid = 1; lk_src = src; lk_masked = 0; lk_keep_byte = 0; lk_subop = 1;
        wr_op = 2'd2; wr_index = 8'd123; wr_data = {NSEL{32'h0000_00A7}};
        @(negedge clk);
        lk_valid = 0; wr_op = 0;
        model_write(2'd2, 2'd0, 8'd123, {NSEL{32'h0000_00A7}});
        chk("R10 old data", res_data, e_old);
        do_lookup("R10 new data", src, 1'b0, 2'd0, 1'b1);
    endtask

    // R2, R11: back-to-back and hold
    task automatic t_timing;
        logic [W-1:0] e1, e2, held;
        e1 = exp_res(mk_src(60), 1'b0, 2'd0, 1'b0);
        e2 = exp_res(mk_src(61), 1'b0, 2'd0, 1'b1);
        @(negedge clk);
        lk_valid = 1; lk_src = mk_src(60); lk_subop = 0; lk_masked = 0;
        @(negedge clk);
        chk("R2 b2b first valid", W'(res_valid), W'(1));
        chk("R2 b2b first data", res_data, e1);
        lk_src = mk_src(61); lk_subop = 1;
        @(negedge clk);
        lk_valid = 0; lk_src = mk_src(62); lk_subop = 0;
        chk("R2 b2b second valid", W'(res_valid), W'(1));
        chk("R2 b2b second data", res_data, e2);
        held = res_data;
        @(negedge clk);
        chk("R2 drop valid", W'(res_valid), W'(0));
        chk("R11 hold", res_data, held);
        @(negedge clk);
        chk("R11 hold later", res_data, held);
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_fill();
        t_fold();
        t_pack();
        t_mask();
        t_stride_iso();
        t_broadcast();
        t_nowrite();
        t_same_cycle();
        t_timing();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule